// File: doc/BRIEF.md
# Two-wire byte core with status and interrupt

This block is the byte-level engine of a two-wire serial peripheral. A bit-level front end hands it decoded bus events: start, stop, a sampled data bit, the end of a byte, the sampled acknowledge bit, a lost arbitration and the presence of another master. From these it keeps an 8-bit shift register and a read-only status byte. It tells the block's own slave address or a general call apart from any other address, and it decides which acknowledge to drive. It raises one interrupt flag on a fixed set of qualified events.

The CPU chooses master or slave operation and the transfer direction, and it controls address acknowledge (the AA control) and general-call response. The interrupt flag clears itself when the CPU reads the status byte. An event in the same cycle as that read keeps the flag set. Every output is registered and changes on the clock edge after the event that causes it.

Top module: `i2c_byte_status`

## Requirements
- R1: After reset the status byte, data byte, ack drive and interrupt are all 0.
- R2: Each bit event shifts `bit_val` into data bit 0 and moves the older bits toward bit 7, so after 8 bit events the data byte equals the bus byte, with the first bit in bit 7.
- R3: At the end of the first byte after a start in slave operation, with `aa_en`=1 and data[7:1] equal to `own_addr`: the interrupt is set, status bit 0 (slave) is set, status bit 4 (transmitter) takes data bit 0, and `ack_out` (1 = drive ACK) is 1.
- R4: An address byte with data[7:1]=0 while `gc_en`=1 and `aa_en`=1 also sets status bit 7 (general call) and bit 0, with bit 4 cleared. With `gc_en`=0 it causes no match (own address nonzero).
- R5: A mismatched address, or any address while `aa_en`=0, raises no interrupt, sets no slave bit and drives no ACK. Later bytes and the stop in that transfer raise no interrupt.
- R6: In master operation (`master_mode`=1 at start) every byte end sets the interrupt, also after `arb_lost`. Status bit 2 is set by `arb_lost` and cleared by start. Status bit 4 follows `master_tx` one cycle later.
- R7: A byte end while the block is the addressed slave sets the interrupt. `ack_out` is `aa_en` when the slave receives (bit 4 = 0) and 0 when it transmits.
- R8: A stop while the block is the addressed slave sets status bit 6 and the interrupt and clears bit 0. A start clears bits 7, 6, 4, 2 and 0.
- R9: A cycle with `sta_rd` clears the interrupt (status bit 5) on the next edge. If a qualifying event arrives in the same cycle, the interrupt stays set.
- R10: Status bit 1 takes `ack_val` at each ack event (1 = NACK received). Status bit 3 shows `other_busy`, delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_bit | input | 1 | A data bit was sampled |
| bit_val | input | 1 | Value of the sampled bit |
| ev_byte_end | input | 1 | Eighth bit of a byte completed |
| ev_ack | input | 1 | Acknowledge bit sampled |
| ack_val | input | 1 | Sampled acknowledge, 1 = NACK |
| arb_lost | input | 1 | Arbitration lost pulse |
| other_busy | input | 1 | Another master holds the bus |
| own_addr | input | 7 | Own slave address |
| gc_en | input | 1 | Respond to general call |
| aa_en | input | 1 | Acknowledge enable |
| master_mode | input | 1 | Act as master for the next transfer |
| master_tx | input | 1 | Master direction, 1 = transmit |
| sta_rd | input | 1 | CPU reads the status byte |
| status | output | 8 | Status: gc, stop, irq, tx, busy, arb, nack, slave (bit 7..0) |
| data | output | 8 | Data shift register |
| ack_out | output | 1 | 1 = drive ACK in the next ack slot |
| irq | output | 1 | Interrupt flag |

## Verification
The stimulus is a random set of address bytes. Each byte is the block's own address, the zero address, or a random value, and it is combined with random AA, general-call enable and read/write bits. This separates a match from a general call and from a mismatch, and it shows whether AA gates the match. Each matched transfer continues with a data byte and a stop, which shows the receive/transmit ack choice and the stop flag. Each ignored transfer does the same and must stay silent. Directed cases cover master bytes after lost arbitration, a status read that collides with an event, the NACK and bus-busy bits, and the start clearing the flags.

// File: rtl/i2c_byte_status.sv
module i2c_byte_status #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_bit,
  input  logic          bit_val,
  input  logic          ev_byte_end,
  input  logic          ev_ack,
  input  logic          ack_val,
  input  logic          arb_lost,
  input  logic          other_busy,
  input  logic [AW-1:0] own_addr,
  input  logic          gc_en,
  input  logic          aa_en,
  input  logic          master_mode,
  input  logic          master_tx,
  input  logic          sta_rd,
  output logic [7:0]    status,
  output logic [DW-1:0] data,
  output logic          ack_out,
  output logic          irq
);
  typedef enum logic [2:0] {IDLE, ADR, SLV, MST, IGN} phase_t;
  phase_t ph;

  logic [DW-1:0] dat;
  logic gc_q, stp_q, irq_q, tx_q, busy_q, arb_q, nack_q, slv_q, ack_q;

  wire hit_gc  = aa_en && gc_en && (dat[DW-1:1] == '0);
  wire hit_own = aa_en && (dat[DW-1:1] == own_addr);
  wire be      = ev_byte_end && !ev_start && !ev_stop;
  wire irq_set = (be && ((ph == ADR && (hit_gc || hit_own)) || ph == SLV || ph == MST))
              || (ev_stop && !ev_start && ph == SLV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= IDLE; dat <= '0;
      gc_q <= 1'b0; stp_q <= 1'b0; irq_q <= 1'b0; tx_q <= 1'b0;
      busy_q <= 1'b0; arb_q <= 1'b0; nack_q <= 1'b0; slv_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      busy_q <= other_busy;
      if (irq_set) irq_q <= 1'b1;
      else if (sta_rd) irq_q <= 1'b0;
      if (ev_bit) begin
        dat   <= {dat[DW-2:0], bit_val};
        ack_q <= 1'b0;
      end
      if (ev_ack) nack_q <= ack_val;
      if (arb_lost) arb_q <= 1'b1;
      if (ph == MST) tx_q <= master_tx;
      if (ev_start) begin
        ph <= master_mode ? MST : ADR;
        gc_q <= 1'b0; stp_q <= 1'b0; slv_q <= 1'b0;
        arb_q <= 1'b0; tx_q <= 1'b0; ack_q <= 1'b0;
      end else if (ev_stop) begin
        ph <= IDLE; slv_q <= 1'b0; tx_q <= 1'b0; ack_q <= 1'b0;
        if (ph == SLV) stp_q <= 1'b1;
      end else if (ev_byte_end) begin
        case (ph)
          ADR: begin
            if (hit_gc) begin
              ph <= SLV; gc_q <= 1'b1; slv_q <= 1'b1; tx_q <= 1'b0; ack_q <= 1'b1;
            end else if (hit_own) begin
              ph <= SLV; slv_q <= 1'b1; tx_q <= dat[0]; ack_q <= 1'b1;
            end else begin
              ph <= IGN;
            end
          end
          SLV:     ack_q <= aa_en && !tx_q;
          MST:     ack_q <= aa_en && !master_tx;
          default: ack_q <= 1'b0;
        endcase
      end
    end
  end

  assign status  = {gc_q, stp_q, irq_q, tx_q, busy_q, arb_q, nack_q, slv_q};
  assign data    = dat;
  assign ack_out = ack_q;
  assign irq     = irq_q;
endmodule

// File: rtl/i2c_byte_status_chk.sv
module i2c_byte_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_byte_end,
  input logic       ev_ack,
  input logic       ack_val,
  input logic       arb_lost,
  input logic       sta_rd,
  input logic [7:0] status,
  input logic       irq
);
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_byte_end || ev_stop));
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_rd && !ev_byte_end && !ev_stop) |=> !irq);
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (!status[7] && !status[6] && !status[0] && !status[2]));
  a_r8_stop_as_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_start && status[0]) |=> (status[6] && irq && !status[0]));
  a_r10_nack_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> (status[1] == $past(ack_val)));
  a_r6_arb_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !ev_start) |=> status[2]);
  a_r9_irq_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] == irq);
endmodule

bind i2c_byte_status i2c_byte_status_chk u_chk (.*);

// File: tb/sim_i2c_byte_status.sv
`timescale 1ns/1ps
module sim_i2c_byte_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_bit = 0, bit_val = 0, ev_byte_end = 0;
  logic ev_ack = 0, ack_val = 0, arb_lost = 0, other_busy = 0;
  logic [6:0] own_addr = 7'h2A;
  logic gc_en = 0, aa_en = 1, master_mode = 0, master_tx = 0, sta_rd = 0;
  logic [7:0] status, data;
  logic ack_out, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_byte_status u0 (.*);

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start; ev_start = 1; tick; ev_start = 0; endtask
  task automatic do_stop;  ev_stop = 1;  tick; ev_stop = 0;  endtask
  task automatic do_read;  sta_rd = 1;   tick; sta_rd = 0;   endtask
  task automatic do_end;   ev_byte_end = 1; tick; ev_byte_end = 0; endtask
  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      ev_bit = 1; bit_val = b[i]; tick;
    end
    ev_bit = 0;
  endtask

  function automatic logic [8:0] exp_addr(input logic [7:0] b, input logic [6:0] own,
                                          input logic aa, input logic gc);
    logic gm, om;
    gm = aa && gc && (b[7:1] == 0);
    om = aa && (b[7:1] == own) && !gm;
    return {gm | om, gm, 1'b0, gm | om, om ? b[0] : 1'b0, 3'b000, gm | om};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] e;
    logic [7:0] b, d;
    process::self().srandom(32'd1234);
    tick; tick;
    chk("R1 status", status, 8'h00); chk("R1 data", data, 8'h00);
    chk("R1 ack", ack_out, 0);       chk("R1 irq", irq, 0);
    rst_n = 1; tick;

    send_bits(8'hA5);
    chk("R2 shift", data, 8'hA5);
    send_bits(8'h3C);
    chk("R2 shift", data, 8'h3C);

    for (int n = 0; n < 60; n++) begin
      own_addr = 7'($urandom_range(1, 127));
      aa_en = ($urandom_range(0, 3) != 0);
      gc_en = $urandom_range(0, 1);
      case ($urandom_range(0, 2))
        0: b = {own_addr, 1'($urandom_range(0, 1))};
        1: b = {7'h00, 1'b0};
        default: b = 8'($urandom);
      endcase
      e = exp_addr(b, own_addr, aa_en, gc_en);
      do_read;
      do_start;
      send_bits(b);
      do_end;
      chk("R3 R4 R5 addr status", status, e[7:0]);
      chk("R3 R4 R5 addr ack", ack_out, e[8]);
      chk("R3 R5 addr irq", irq, e[5]);
      do_read;
      d = 8'($urandom);
      send_bits(d);
      do_end;
      if (e[0]) begin
        chk("R7 slave byte irq", irq, 1);
        chk("R7 slave ack", ack_out, aa_en && !e[4]);
      end else begin
        chk("R5 ignored byte irq", irq, 0);
        chk("R5 ignored ack", ack_out, 0);
      end
      do_read;
      do_stop;
      if (e[0]) chk("R8 stop as slave", status, {e[7], 1'b1, 1'b1, 5'b00000});
      else      chk("R5 stop ignored", status, 8'h00);
    end

    own_addr = 7'h15; gc_en = 0; aa_en = 1;
    do_read; do_start; send_bits(8'h00); do_end;
    chk("R4 gc disabled", status, 8'h00);
    do_stop;

    master_mode = 1; master_tx = 1; do_read;
    do_start;
    tick;
    chk("R6 master tx flag", status[4], 1);
    arb_lost = 1; tick; arb_lost = 0;
    send_bits(8'h96);
    do_end;
    chk("R6 master byte after arb lost", status, 8'h34);
    master_tx = 0; tick;
    chk("R6 tx follows", status[4], 0);
    sta_rd = 1; ev_byte_end = 1; tick; sta_rd = 0; ev_byte_end = 0;
    chk("R9 event beats read", irq, 1);
    chk("R6 master rx ack", ack_out, 1);
    do_read;
    chk("R9 read clears", irq, 0);
    chk("R9 status irq bit", status[5], 0);
    do_start;
    chk("R8 start clears arb", status[2], 0);
    do_stop;
    master_mode = 0;

    ack_val = 1; ev_ack = 1; tick; ev_ack = 0;
    chk("R10 nack set", status[1], 1);
    ack_val = 0; ev_ack = 1; tick; ev_ack = 0;
    chk("R10 nack clear", status[1], 0);
    other_busy = 1; tick;
    chk("R10 busy", status[3], 1);
    other_busy = 0; tick;
    chk("R10 busy clear", status[3], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule